// File: doc/BRIEF.md
# Multichannel Sliding Sum-of-Squares Engine

This block keeps a running sum of squared samples over a sliding window for eight measurement channels. The channels share one input port and one arithmetic path, and their beats may arrive in any interleaving. Every valid beat carries a channel number and a signed 16-bit sample. The engine stores the sample in that channel's history. It then adds the new square to the channel's running sum and removes the square of the sample that has just left the window. The window is 171 samples long, which is about half a mains period at roughly 20.5 kHz.

Each updated sum is put out as a 64-bit value on a streaming output, together with its channel tag, for a downstream event detector. The same sum is also stored in one of two result banks. A host picks one bank for reading with a select bit, and new results always go into the other bank. The host reads a channel's 64-bit value 32 bits at a time. The sum is the energy term only: no square root is taken.

Top module: `sqwin_engine`

## Requirements
- R1: While reset is asserted and afterwards until the first result, `out_valid` is 0, and every readable word (both banks, all channels, both halves) reads 0.
- R2: Each beat accepted with `in_valid`=1 gives exactly one output beat with `out_valid`=1 two clock edges later, and `out_ch` equals the beat's channel. A cycle with `in_valid`=0 gives no output beat.
- R3: `out_sum` equals the sum of the squares of the channel's most recent 171 samples, each sample read as two's complement.
- R4: Before a channel has received 171 samples, the missing older entries count as zero, so the sum ramps up from zero after reset.
- R5: Channels are independent: beats for one channel never change the sum or history of another, whatever the interleaving.
- R6: A result for channel c is written into slot c of the bank that `rd_bank` does not select. The bank that `rd_bank` selects does not change.
- R7: `rd_data` shows bits 63:32 of slot `rd_ch` in bank `rd_bank` when `rd_hi`=1, and bits 31:0 when `rd_hi`=0. It follows these inputs combinationally.
- R8: A full-scale window of -32768 samples gives exactly 171*2^30, with no wrap.
- R9: Beats for the same channel in consecutive cycles are each folded in correctly.
- R10: Removing the oldest square never takes a running sum below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input beat present |
| in_ch | input | 3 | Channel of the input beat |
| in_sample | input | 16 | Signed sample |
| out_valid | output | 1 | Result beat present |
| out_ch | output | 3 | Channel of the result |
| out_sum | output | 64 | Window sum of squares |
| rd_bank | input | 1 | Bank the host reads (results go to the other one) |
| rd_ch | input | 3 | Channel slot the host reads |
| rd_hi | input | 1 | 1: upper 32 bits, 0: lower 32 bits |
| rd_data | output | 32 | Host read word |

## Verification
The assertions assume that `rd_bank`, `rd_ch` and `rd_hi` are sampled at the clock edge like any other input. They also assume that samples are plain 16-bit two's complement values, so a window can never exceed 171*2^30. The stimulus drives all inputs on the falling edge. It changes `rd_bank` only after the pipeline has drained, so every result lands in a known bank. The sample patterns sweep the whole 16-bit range, including -32768, with channels interleaved, idle gaps and same-channel bursts.

// File: rtl/sqwin_pkg.sv
package sqwin_pkg;
  localparam int unsigned DEF_NUM_CH   = 8;
  localparam int unsigned DEF_SAMPLE_W = 16;
  localparam int unsigned DEF_WIN_LEN  = 171;
  localparam int unsigned DEF_ACC_W    = 64;
  localparam int unsigned DEF_HOST_W   = 32;
endpackage

// File: rtl/sqwin_history.sv
module sqwin_history #(
  parameter int unsigned NUM_CH   = sqwin_pkg::DEF_NUM_CH,
  parameter int unsigned SAMPLE_W = sqwin_pkg::DEF_SAMPLE_W,
  parameter int unsigned WIN_LEN  = sqwin_pkg::DEF_WIN_LEN,
  localparam int unsigned CH_W    = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [CH_W-1:0]     in_ch,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                s1_valid,
  output logic [CH_W-1:0]     s1_ch,
  output logic [SAMPLE_W-1:0] s1_new,
  output logic [SAMPLE_W-1:0] s1_old
);
  localparam int unsigned PTR_W  = $clog2(WIN_LEN);
  localparam int unsigned DEPTH  = NUM_CH * WIN_LEN;
  localparam int unsigned ADDR_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(WIN_LEN - 1);

  // Sample storage: no reset, the fill flags mask stale content.
  logic [SAMPLE_W-1:0] mem [DEPTH];

  logic [PTR_W-1:0] ptr_q   [NUM_CH];
  logic [PTR_W-1:0] ptr_d   [NUM_CH];
  logic [NUM_CH-1:0] full_q, full_d;

  logic [PTR_W-1:0]    ptr_sel;
  logic [ADDR_W-1:0]   addr;
  logic [SAMPLE_W-1:0] old_raw, old_eff;

  always_comb begin
    ptr_sel = ptr_q[in_ch];
    addr    = ADDR_W'(in_ch) * ADDR_W'(WIN_LEN) + ADDR_W'(ptr_sel);
    old_raw = mem[addr];
    old_eff = full_q[in_ch] ? old_raw : '0;
  end

  always_comb begin
    full_d = full_q;
    for (int c = 0; c < NUM_CH; c++) begin
      ptr_d[c] = ptr_q[c];
      if (in_valid && (in_ch == CH_W'(c))) begin
        if (ptr_q[c] == PTR_LAST) begin
          ptr_d[c]  = '0;
          full_d[c] = 1'b1;
        end else begin
          ptr_d[c] = ptr_q[c] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) mem[addr] <= in_sample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) ptr_q[c] <= '0;
      full_q <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) ptr_q[c] <= ptr_d[c];
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_ch    <= '0;
      s1_new   <= '0;
      s1_old   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_ch  <= in_ch;
        s1_new <= in_sample;
        s1_old <= old_eff;
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ptr_chk
      AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q[g] <= PTR_LAST); // R3
    end
  endgenerate
endmodule

// File: rtl/sqwin_accum.sv
module sqwin_accum #(
  parameter int unsigned NUM_CH   = sqwin_pkg::DEF_NUM_CH,
  parameter int unsigned SAMPLE_W = sqwin_pkg::DEF_SAMPLE_W,
  parameter int unsigned WIN_LEN  = sqwin_pkg::DEF_WIN_LEN,
  parameter int unsigned ACC_W    = sqwin_pkg::DEF_ACC_W,
  localparam int unsigned CH_W    = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s1_valid,
  input  logic [CH_W-1:0]     s1_ch,
  input  logic [SAMPLE_W-1:0] s1_new,
  input  logic [SAMPLE_W-1:0] s1_old,
  output logic                out_valid,
  output logic [CH_W-1:0]     out_ch,
  output logic [ACC_W-1:0]    out_sum
);
  localparam int unsigned SQ_W = 2 * SAMPLE_W;
  localparam logic [ACC_W-1:0] MAX_SUM = ACC_W'(WIN_LEN) << (SQ_W - 2);

  logic [ACC_W-1:0] sum_q [NUM_CH];
  logic [ACC_W-1:0] sum_d [NUM_CH];

  logic signed [SAMPLE_W-1:0] new_s, old_s;
  logic signed [SQ_W-1:0]     sq_new_s, sq_old_s;
  logic [ACC_W-1:0]           sq_new, sq_old, sum_cur, sum_upd;

  always_comb begin
    new_s    = s1_new;
    old_s    = s1_old;
    sq_new_s = new_s * new_s;
    sq_old_s = old_s * old_s;
    sq_new   = ACC_W'($unsigned(sq_new_s));
    sq_old   = ACC_W'($unsigned(sq_old_s));
    sum_cur  = sum_q[s1_ch];
    sum_upd  = sum_cur + sq_new - sq_old;
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      sum_d[c] = sum_q[c];
      if (s1_valid && (s1_ch == CH_W'(c))) sum_d[c] = sum_upd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) sum_q[c] <= '0;
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_sum   <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) sum_q[c] <= sum_d[c];
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_ch  <= s1_ch;
        out_sum <= sum_upd;
      end
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> (sum_cur + sq_new >= sq_old)); // R10
  AST_SUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sum <= MAX_SUM)); // R8
endmodule

// File: rtl/sqwin_bank.sv
module sqwin_bank #(
  parameter int unsigned NUM_CH = sqwin_pkg::DEF_NUM_CH,
  parameter int unsigned ACC_W  = sqwin_pkg::DEF_ACC_W,
  parameter int unsigned HOST_W = sqwin_pkg::DEF_HOST_W,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [ACC_W-1:0]  wr_data,
  input  logic              rd_bank,
  input  logic [CH_W-1:0]   rd_ch,
  input  logic              rd_hi,
  output logic [HOST_W-1:0] rd_data
);
  localparam int unsigned NUM_BANK = 2;

  logic [ACC_W-1:0] bank_q [NUM_BANK][NUM_CH];
  logic [ACC_W-1:0] bank_d [NUM_BANK][NUM_CH];
  logic             wr_bank;
  logic [ACC_W-1:0] word;

  always_comb begin
    wr_bank = ~rd_bank;
    for (int b = 0; b < NUM_BANK; b++) begin
      for (int c = 0; c < NUM_CH; c++) begin
        bank_d[b][c] = bank_q[b][c];
        if (wr_en && (wr_bank == b[0]) && (wr_ch == CH_W'(c)))
          bank_d[b][c] = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANK; b++)
        for (int c = 0; c < NUM_CH; c++) bank_q[b][c] <= '0;
    end else begin
      for (int b = 0; b < NUM_BANK; b++)
        for (int c = 0; c < NUM_CH; c++) bank_q[b][c] <= bank_d[b][c];
    end
  end

  always_comb begin
    word    = bank_q[rd_bank][rd_ch];
    rd_data = rd_hi ? word[ACC_W-1 -: HOST_W] : word[HOST_W-1:0];
  end

  AST_READ_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_bank) && $stable(rd_ch) && $stable(rd_hi)) |-> $stable(rd_data)); // R6
endmodule

// File: rtl/sqwin_engine.sv
module sqwin_engine #(
  parameter int unsigned NUM_CH   = sqwin_pkg::DEF_NUM_CH,
  parameter int unsigned SAMPLE_W = sqwin_pkg::DEF_SAMPLE_W,
  parameter int unsigned WIN_LEN  = sqwin_pkg::DEF_WIN_LEN,
  parameter int unsigned ACC_W    = sqwin_pkg::DEF_ACC_W,
  parameter int unsigned HOST_W   = sqwin_pkg::DEF_HOST_W,
  localparam int unsigned CH_W    = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [CH_W-1:0]     in_ch,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                out_valid,
  output logic [CH_W-1:0]     out_ch,
  output logic [ACC_W-1:0]    out_sum,
  input  logic                rd_bank,
  input  logic [CH_W-1:0]     rd_ch,
  input  logic                rd_hi,
  output logic [HOST_W-1:0]   rd_data
);
  // Reset: asserted asynchronously, released on the second clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic                s1_valid;
  logic [CH_W-1:0]     s1_ch;
  logic [SAMPLE_W-1:0] s1_new, s1_old;

  sqwin_history #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .WIN_LEN(WIN_LEN)
  ) u_history (
    .clk(clk), .rst_n(rst_ni),
    .in_valid(in_valid), .in_ch(in_ch), .in_sample(in_sample),
    .s1_valid(s1_valid), .s1_ch(s1_ch), .s1_new(s1_new), .s1_old(s1_old)
  );

  sqwin_accum #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .WIN_LEN(WIN_LEN), .ACC_W(ACC_W)
  ) u_accum (
    .clk(clk), .rst_n(rst_ni),
    .s1_valid(s1_valid), .s1_ch(s1_ch), .s1_new(s1_new), .s1_old(s1_old),
    .out_valid(out_valid), .out_ch(out_ch), .out_sum(out_sum)
  );

  sqwin_bank #(
    .NUM_CH(NUM_CH), .ACC_W(ACC_W), .HOST_W(HOST_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_ni),
    .wr_en(out_valid), .wr_ch(out_ch), .wr_data(out_sum),
    .rd_bank(rd_bank), .rd_ch(rd_ch), .rd_hi(rd_hi), .rd_data(rd_data)
  );

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid |-> $past(in_valid, 2)); // R2
  AST_OUT_CHANNEL: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid |-> (out_ch == $past(in_ch, 2))); // R2
endmodule

// File: tb/sqwin_engine_bench.sv
module sqwin_engine_bench;
  localparam int NCH = 8;
  localparam int WIN = 171;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  in_ch;
  logic [15:0] in_sample;
  logic        out_valid;
  logic [2:0]  out_ch;
  logic [63:0] out_sum;
  logic        rd_bank;
  logic [2:0]  rd_ch;
  logic        rd_hi;
  logic [31:0] rd_data;

  always #2 clk = ~clk;

  sqwin_engine u_sqwin_engine (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ch(in_ch), .in_sample(in_sample),
    .out_valid(out_valid), .out_ch(out_ch), .out_sum(out_sum),
    .rd_bank(rd_bank), .rd_ch(rd_ch), .rd_hi(rd_hi), .rd_data(rd_data)
  );

  int     n_chk = 0;
  int     n_fail = 0;
  bit     done = 0;

  int     hist [NCH][WIN];
  int     wp   [NCH];
  int     cnt  [NCH];
  longint mbank [2][NCH];

  bit     p1_v, p2_v;
  int     p1_ch, p2_ch;
  longint p1_s, p2_s;
  string  p1_tag, p2_tag;

  function automatic longint win_sum(int c);
    longint s = 0;
    for (int k = 0; k < WIN; k++) s += longint'(hist[c][k]) * longint'(hist[c][k]);
    return s;
  endfunction

  task automatic check64(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One cycle: check the beat from two cycles ago, then drive a new one.
  task automatic step(bit v, int c, logic [15:0] s);
    @(negedge clk);
    n_chk++;
    if (p2_v) begin
      if (!out_valid || out_ch != 3'(p2_ch) || out_sum != 64'(p2_s)) begin
        n_fail++;
        $display("FAIL %s: actual v=%0d ch=%0d sum=%0d expected v=1 ch=%0d sum=%0d",
                 p2_tag, out_valid, out_ch, out_sum, p2_ch, p2_s);
      end
      mbank[~rd_bank][p2_ch] = p2_s;
    end else if (out_valid) begin
      n_fail++;
      $display("FAIL R2 idle: actual out_valid=1 expected 0");
    end
    p2_v = p1_v; p2_ch = p1_ch; p2_s = p1_s; p2_tag = p1_tag;
    in_valid = v; in_ch = 3'(c); in_sample = s;
    p1_v = v; p1_ch = c;
    if (v) begin
      p1_tag = (cnt[c] < WIN) ? "R4 ramp" : "R3/R5 window";
      hist[c][wp[c]] = int'($signed(s));
      wp[c] = (wp[c] + 1) % WIN;
      cnt[c]++;
      p1_s = win_sum(c);
    end
  endtask

  task automatic read_all(string tag);
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < NCH; c++)
        for (int h = 0; h < 2; h++) begin
          @(negedge clk);
          rd_bank = b[0]; rd_ch = 3'(c); rd_hi = h[0];
          #1;
          check64(tag, longint'(rd_data),
                  h ? longint'(mbank[b][c] >>> 32) : (mbank[b][c] & 64'hFFFF_FFFF));
        end
  endtask

  task automatic drain();
    for (int k = 0; k < 3; k++) step(1'b0, 0, 16'h0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      wp[c] = 0; cnt[c] = 0;
      for (int k = 0; k < WIN; k++) hist[c][k] = 0;
      mbank[0][c] = 0; mbank[1][c] = 0;
    end
    p1_v = 0; p2_v = 0; p1_ch = 0; p2_ch = 0; p1_s = 0; p2_s = 0;
    p1_tag = ""; p2_tag = "";
    rst_n = 1'b0; in_valid = 1'b0; in_ch = 3'd0; in_sample = 16'h0;
    rd_bank = 1'b0; rd_ch = 3'd0; rd_hi = 1'b0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check64("R1 out_valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check64("R1 out_valid after reset", longint'(out_valid), 0);
    read_all("R1 bank reset");

    // R2 R3 R4 R5: interleaved channels, sweeping values, idle gaps
    rd_bank = 1'b0;
    for (int i = 0; i < 2600; i++) begin
      int c = (i * 3 + i / 7) % NCH;
      int raw = (i * 7919 + c * 4513 + (i * i) % 97) & 32'hFFFF;
      if (i % 5 == 3) step(1'b0, c, 16'h0);
      step(1'b1, c, raw[15:0]);
    end
    drain();
    // R6 R7: results land in bank 1, bank 0 stays zero
    read_all("R6/R7 bank read A");

    // R8 R9: full-scale back-to-back burst on one channel, bank swapped
    rd_bank = 1'b1;
    for (int i = 0; i < 200; i++) step(1'b1, 5, 16'h8000);
    drain();
    check64("R8 full scale", mbank[0][5], longint'(WIN) * (longint'(1) << 30));
    // R9: alternating same-channel and other-channel bursts
    for (int i = 0; i < 400; i++) begin
      int c = (i / 4) % 2 ? 2 : 6;
      int raw = (i * 40503 + 12345) & 32'hFFFF;
      step(1'b1, c, raw[15:0]);
    end
    drain();
    read_all("R6/R7 bank read B");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule